// File: doc/BRIEF.md
# Password-Locked Block Access Controller

This block decides whether the currently selected block of a partitioned storage array may be read or written. Every block can carry a password of one, two or three 32-bit words, a lock flag and a one-bit protection mode. From those three it derives two level outputs, `rd_allow` and `wr_allow`, for the block that the select register names. The storage array is not part of this block.

Software works through a small register port. It picks a block, enters that block's password word by word into an unlock register, and can write a new password and protection setting once the block is unlocked. Block 0 acts as the master. While block 0 has a password and is locked, the only register that accepts writes is the unlock register, and the select register stays at 0. A separate preload port loads a block's password, length and mode without any check, as a start-up loader would. Stored passwords, lengths and modes keep their values through reset. Lock flags do not: reset sets every lock flag.

Unlock progress is tracked by a three-state machine. The states are SEQ_W0, SEQ_W1 and SEQ_W2, meaning the next unlock write is compared against password word 0, 1 or 2.
- A matching word that is not the last one advances SEQ_W0→SEQ_W1→SEQ_W2.
- A matching final word clears the lock flag and returns to SEQ_W0.
- A mismatch, the relock value, a write to a block with no password, or an abort returns to SEQ_W0.
- An abort is an accepted select write, an accepted password or access write, or a preload.

Top module: `pw_access_ctrl`

## Requirements
- R1: Reset sets blk_sel to 0 and sets every lock flag. It returns the sequencer to SEQ_W0. Stored password words, lengths and modes are not changed by reset, so every block with a password is locked afterwards.
- R2: A block with length 0 (no password) and mode 0 has rd_allow=1 and wr_allow=1.
- R3: A block with a password, mode 0 and its lock flag set has rd_allow=1 and wr_allow=0. Once unlocked it has rd_allow=1 and wr_allow=1.
- R4: A block with a password and mode 1 has rd_allow=0 and wr_allow=0 while locked, and both at 1 while unlocked. A block with mode 1 and no password has both at 1.
- R5: Unlock writes (address 1) are compared against password word 0, then word 1, then word 2. Word 0 is bits 31:0 of the password. The lock flag clears in the cycle after the write of word number length-1. Unlock writes to a block with no password have no effect.
- R6: An unlock word that does not match the expected word returns the sequence to word 0 and leaves the block locked. A complete correct sequence that starts afterwards unlocks the block.
- R7: An unlock write of 0xFFFFFFFF sets the lock flag of the selected block and restarts the sequence. With block 0 selected, this locks the whole module.
- R8: While block 0 has a password and is locked, writes to address 0 (select), addresses 2–4 (password words 0–2) and address 5 (access) are ignored, and blk_sel stays 0.
- R9: Writes to addresses 2–4 and 5 go to the selected block and take effect only while that block has no password or is unlocked. Address 5 holds the length in bits 1:0 (0 means no password) and the mode in bit 4. A block that gets a password through address 5 while its lock flag is set becomes locked at once.
- R10: An accepted select write, even one that re-selects the same block, restarts the unlock sequence at word 0.
- R11: A select write whose value is NBLK or larger is ignored.
- R12: Reads return the following:
  - address 0: blk_sel in the low bits;
  - address 1: the selected block's effective lock in bit 0 and the module lock (block 0 locked) in bit 1;
  - address 5: the access field;
  - addresses 2–4 and all others: zero.
- R13: A preload (pl_valid) writes the password, length and mode of block pl_blk without any check and sets that block's lock flag. A preload of block 0 with a nonzero length also forces blk_sel to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_valid | input | 1 | Preload strobe |
| pl_blk | input | SELW | Block to preload |
| pl_len | input | 2 | Preloaded password length in words, 0 = none |
| pl_prot | input | 1 | Preloaded protection mode |
| pl_pw | input | 3*WORD_W | Preloaded password, word 0 in the low bits |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Register read data (combinational) |
| blk_sel | output | SELW | Currently selected block |
| rd_allow | output | 1 | Read permitted for the selected block |
| wr_allow | output | 1 | Write permitted for the selected block |

## Verification
The bench builds the block with NBLK=5 and WORD_W=32, which gives a 3-bit select field. Select codes 5 to 7 are therefore legal bit patterns with no block behind them, so the out-of-range rule of R11 can be exercised. The five blocks are preloaded with every combination the decode distinguishes:
- no password, in mode 0 and in mode 1;
- one-word, two-word and three-word passwords;
- both modes with a password.

With these settings the master gate, the full three-word sequence, aborts and the retention of stored values across reset can all be reached.

// File: rtl/pwac_pkg.sv
`timescale 1ns/1ps
package pwac_pkg;
    localparam int MAX_WORDS = 3;
    localparam int LEN_W     = 2;

    typedef enum logic [1:0] {
        SEQ_W0 = 2'd0,
        SEQ_W1 = 2'd1,
        SEQ_W2 = 2'd2
    } seq_state_e;

    typedef enum logic {
        PROT_GUARD_WR = 1'b0,
        PROT_GUARD_RW = 1'b1
    } prot_e;

    localparam logic [2:0] A_SEL    = 3'd0;
    localparam logic [2:0] A_UNLOCK = 3'd1;
    localparam logic [2:0] A_PW0    = 3'd2;
    localparam logic [2:0] A_ACCESS = 3'd5;
    localparam int         ACC_PROT_BIT = 4;
endpackage

// File: rtl/pwac_unlock_seq.sv
`timescale 1ns/1ps
module pwac_unlock_seq
    import pwac_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int PW_W  = MAX_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              unl_we,
    input  logic [WORD_W-1:0] unl_data,
    input  logic [PW_W-1:0]   pw,
    input  logic [LEN_W-1:0]  len,
    output logic              do_unlock,
    output logic              do_relock
);
    localparam logic [WORD_W-1:0] RELOCK_WORD = '1;

    seq_state_e        state_q, state_d;
    logic [WORD_W-1:0] expect_w;
    logic              has_pw;
    logic              final_w;
    logic              is_relock;
    logic              match;

    always_comb begin
        unique case (state_q)
            SEQ_W0:  expect_w = pw[0 +: WORD_W];
            SEQ_W1:  expect_w = pw[WORD_W +: WORD_W];
            SEQ_W2:  expect_w = pw[2*WORD_W +: WORD_W];
            default: expect_w = pw[0 +: WORD_W];
        endcase
    end

    assign has_pw    = (len != '0);
    assign final_w   = ({1'b0, state_q} + 3'd1) >= {1'b0, len};
    assign is_relock = (unl_data == RELOCK_WORD);
    assign match     = has_pw && !is_relock && (unl_data == expect_w);

    // next state
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = SEQ_W0;
        end else if (unl_we) begin
            if (is_relock || !match) begin
                state_d = SEQ_W0;
            end else if (final_w) begin
                state_d = SEQ_W0;
            end else begin
                unique case (state_q)
                    SEQ_W0:  state_d = SEQ_W1;
                    SEQ_W1:  state_d = SEQ_W2;
                    default: state_d = SEQ_W0;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_W0;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        do_unlock = 1'b0;
        do_relock = 1'b0;
        if (unl_we && !abort) begin
            if (is_relock)              do_relock = 1'b1;
            else if (match && final_w)  do_unlock = 1'b1;
        end
    end

    p_abort_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> state_q == SEQ_W0);

    p_mismatch_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_we && !abort && has_pw && !is_relock && unl_data != expect_w)
        |=> state_q == SEQ_W0);

    p_relock_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_we && is_relock) |=> state_q == SEQ_W0);

    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_we && !abort && match && !final_w) |=> state_q != $past(state_q));
endmodule

// File: rtl/pwac_store.sv
`timescale 1ns/1ps
module pwac_store
    import pwac_pkg::*;
#(
    parameter int NBLK   = 4,
    parameter int WORD_W = 32,
    parameter int SELW   = 2,
    localparam int PW_W  = MAX_WORDS * WORD_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SELW-1:0]                sel,
    input  logic                           pl_ok,
    input  logic [SELW-1:0]                pl_blk,
    input  logic [LEN_W-1:0]               pl_len,
    input  logic                           pl_prot,
    input  logic [PW_W-1:0]                pl_pw,
    input  logic [MAX_WORDS-1:0]           pw_we,
    input  logic                           acc_we,
    input  logic [WORD_W-1:0]              wdata,
    input  logic                           do_unlock,
    input  logic                           do_relock,
    output logic [NBLK-1:0][PW_W-1:0]      pw_all,
    output logic [NBLK-1:0][LEN_W-1:0]     len_all,
    output logic [NBLK-1:0]                prot_all,
    output logic [NBLK-1:0]                lock_all
);
    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        logic hit_pl;
        logic hit_sel;
        assign hit_pl  = pl_ok && (pl_blk == SELW'(i));
        assign hit_sel = (sel == SELW'(i));

        // retained configuration: no reset
        always_ff @(posedge clk) begin
            if (hit_pl) begin
                pw_all[i]   <= pl_pw;
                len_all[i]  <= pl_len;
                prot_all[i] <= pl_prot;
            end else if (hit_sel) begin
                for (int k = 0; k < MAX_WORDS; k++) begin
                    if (pw_we[k]) pw_all[i][k*WORD_W +: WORD_W] <= wdata;
                end
                if (acc_we) begin
                    len_all[i]  <= wdata[LEN_W-1:0];
                    prot_all[i] <= wdata[ACC_PROT_BIT];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    lock_all[i] <= 1'b1;
            else if (hit_pl)               lock_all[i] <= 1'b1;
            else if (hit_sel && do_relock) lock_all[i] <= 1'b1;
            else if (hit_sel && do_unlock) lock_all[i] <= 1'b0;
        end

        p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_all[i] && len_all[i] != '0 && !hit_pl)
            |=> $stable(len_all[i]) && $stable(prot_all[i]) && $stable(pw_all[i]));

        p_unlock_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lock_all[i]) |-> $past(do_unlock && sel == SELW'(i)));
    end
endmodule

// File: rtl/pwac_grant.sv
`timescale 1ns/1ps
module pwac_grant
    import pwac_pkg::*;
(
    input  logic  has_pw,
    input  logic  locked,
    input  prot_e prot,
    output logic  rd_ok,
    output logic  wr_ok
);
    always_comb begin
        rd_ok = 1'b1;
        wr_ok = 1'b1;
        if (has_pw) begin
            unique case (prot)
                PROT_GUARD_WR: begin
                    rd_ok = 1'b1;
                    wr_ok = !locked;
                end
                PROT_GUARD_RW: begin
                    rd_ok = !locked;
                    wr_ok = !locked;
                end
                default: begin
                    rd_ok = 1'b0;
                    wr_ok = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pw_access_ctrl.sv
`timescale 1ns/1ps
module pw_access_ctrl
    import pwac_pkg::*;
#(
    parameter int NBLK   = 4,
    parameter int WORD_W = 32,
    localparam int SELW  = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int PW_W  = MAX_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_valid,
    input  logic [SELW-1:0]   pl_blk,
    input  logic [LEN_W-1:0]  pl_len,
    input  logic              pl_prot,
    input  logic [PW_W-1:0]   pl_pw,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [SELW-1:0]   blk_sel,
    output logic              rd_allow,
    output logic              wr_allow
);
    logic [SELW-1:0]              sel_q;
    logic [NBLK-1:0][PW_W-1:0]    pw_all;
    logic [NBLK-1:0][LEN_W-1:0]   len_all;
    logic [NBLK-1:0]              prot_all;
    logic [NBLK-1:0]              lock_all;

    logic [PW_W-1:0]      pw_sel;
    logic [LEN_W-1:0]     len_sel;
    logic                 prot_sel;
    logic                 has_sel;
    logic                 sel_locked;
    logic                 master_lk;
    logic                 pl_ok;
    logic                 pl_master;
    logic                 sel_wr;
    logic                 unl_we;
    logic                 cfg_ok;
    logic [MAX_WORDS-1:0] pw_we;
    logic                 acc_we;
    logic                 abort;
    logic                 do_unlock;
    logic                 do_relock;

    assign pw_sel     = pw_all[sel_q];
    assign len_sel    = len_all[sel_q];
    assign prot_sel   = prot_all[sel_q];
    assign has_sel    = (len_sel != '0);
    assign sel_locked = has_sel && lock_all[sel_q];
    assign master_lk  = (len_all[0] != '0) && lock_all[0];

    assign pl_ok     = pl_valid && (32'(pl_blk) < NBLK);
    assign pl_master = pl_ok && (pl_blk == '0) && (pl_len != '0);

    // register write decode
    assign sel_wr = reg_we && (reg_addr == A_SEL) && !master_lk
                    && (reg_wdata < WORD_W'(NBLK));
    assign unl_we = reg_we && (reg_addr == A_UNLOCK);
    assign cfg_ok = !master_lk && !sel_locked;
    always_comb begin
        for (int k = 0; k < MAX_WORDS; k++) begin
            pw_we[k] = reg_we && cfg_ok && (reg_addr == 3'(A_PW0 + k));
        end
    end
    assign acc_we = reg_we && cfg_ok && (reg_addr == A_ACCESS);
    assign abort  = sel_wr || acc_we || (|pw_we) || pl_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sel_q <= '0;
        else if (pl_master) sel_q <= '0;
        else if (sel_wr)    sel_q <= reg_wdata[SELW-1:0];
    end
    assign blk_sel = sel_q;

    // read-back
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_SEL:    reg_rdata[SELW-1:0] = sel_q;
            A_UNLOCK: reg_rdata[1:0] = {master_lk, sel_locked};
            A_ACCESS: begin
                reg_rdata[LEN_W-1:0]     = len_sel;
                reg_rdata[ACC_PROT_BIT]  = prot_sel;
            end
            default:  reg_rdata = '0;
        endcase
    end

    pwac_unlock_seq #(.WORD_W(WORD_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .unl_we    (unl_we),
        .unl_data  (reg_wdata),
        .pw        (pw_sel),
        .len       (len_sel),
        .do_unlock (do_unlock),
        .do_relock (do_relock)
    );

    pwac_store #(.NBLK(NBLK), .WORD_W(WORD_W), .SELW(SELW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_q),
        .pl_ok     (pl_ok),
        .pl_blk    (pl_blk),
        .pl_len    (pl_len),
        .pl_prot   (pl_prot),
        .pl_pw     (pl_pw),
        .pw_we     (pw_we),
        .acc_we    (acc_we),
        .wdata     (reg_wdata),
        .do_unlock (do_unlock),
        .do_relock (do_relock),
        .pw_all    (pw_all),
        .len_all   (len_all),
        .prot_all  (prot_all),
        .lock_all  (lock_all)
    );

    pwac_grant i_grant (
        .has_pw (has_sel),
        .locked (lock_all[sel_q]),
        .prot   (prot_e'(prot_sel)),
        .rd_ok  (rd_allow),
        .wr_ok  (wr_allow)
    );

    p_master_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        master_lk |-> sel_q == '0);

    p_locked_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_locked |-> !wr_allow);

    p_mode1_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_locked && prot_sel) |-> !rd_allow);

    p_sel_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> 32'(sel_q) < NBLK);
endmodule

// File: tb/test_pw_access_ctrl.sv
`timescale 1ns/1ps
module test_pw_access_ctrl;
    import pwac_pkg::*;

    localparam int NB   = 5;
    localparam int WW   = 32;
    localparam int SW   = 3;
    localparam int PWW  = 3 * WW;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           pl_valid;
    logic [SW-1:0]  pl_blk;
    logic [1:0]     pl_len;
    logic           pl_prot;
    logic [PWW-1:0] pl_pw;
    logic           reg_we;
    logic [2:0]     reg_addr;
    logic [WW-1:0]  reg_wdata;
    logic [WW-1:0]  reg_rdata;
    logic [SW-1:0]  blk_sel;
    logic           rd_allow;
    logic           wr_allow;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pw_access_ctrl #(.NBLK(NB), .WORD_W(WW)) i_pw_access_ctrl (
        .clk, .rst_n, .pl_valid, .pl_blk, .pl_len, .pl_prot, .pl_pw,
        .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .blk_sel,
        .rd_allow, .wr_allow
    );

    typedef struct packed {
        logic [2:0]  a;
        logic [31:0] d;
        logic [2:0]  sel;
        logic        rd;
        logic        wr;
        logic [1:0]  st;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam logic [2:0] S = 3'd0;
    localparam logic [2:0] U = 3'd1;
    localparam vec_t VECS [NV] = '{
        '{S, 32'd2,        3'd0, 1'b1, 1'b0, 2'b11, 4'd8},  // R8 select refused
        '{U, 32'h12345678, 3'd0, 1'b1, 1'b0, 2'b11, 4'd6},  // R6
        '{U, 32'hA0A00001, 3'd0, 1'b1, 1'b1, 2'b00, 4'd5},  // R5 one word
        '{U, 32'hFFFFFFFF, 3'd0, 1'b1, 1'b0, 2'b11, 4'd7},  // R7 module relock
        '{U, 32'hA0A00001, 3'd0, 1'b1, 1'b1, 2'b00, 4'd5},  // R5
        '{S, 32'd2,        3'd2, 1'b0, 1'b0, 2'b01, 4'd4},  // R4 mode1 locked
        '{U, 32'h11110001, 3'd2, 1'b0, 1'b0, 2'b01, 4'd5},  // R5
        '{U, 32'h22220002, 3'd2, 1'b0, 1'b0, 2'b01, 4'd5},  // R5
        '{U, 32'h33330003, 3'd2, 1'b1, 1'b1, 2'b00, 4'd5},  // R5 three words
        '{U, 32'hFFFFFFFF, 3'd2, 1'b0, 1'b0, 2'b01, 4'd7},  // R7
        '{U, 32'h11110001, 3'd2, 1'b0, 1'b0, 2'b01, 4'd6},  // R6
        '{U, 32'h99999999, 3'd2, 1'b0, 1'b0, 2'b01, 4'd6},  // R6 mismatch
        '{U, 32'h22220002, 3'd2, 1'b0, 1'b0, 2'b01, 4'd6},  // R6 restarted
        '{U, 32'h11110001, 3'd2, 1'b0, 1'b0, 2'b01, 4'd6},  // R6
        '{U, 32'h22220002, 3'd2, 1'b0, 1'b0, 2'b01, 4'd6},  // R6
        '{U, 32'h33330003, 3'd2, 1'b1, 1'b1, 2'b00, 4'd6},  // R6 recovery
        '{S, 32'd3,        3'd3, 1'b1, 1'b0, 2'b01, 4'd3},  // R3 mode0 locked
        '{U, 32'h44440004, 3'd3, 1'b1, 1'b0, 2'b01, 4'd5},  // R5
        '{S, 32'd3,        3'd3, 1'b1, 1'b0, 2'b01, 4'd10}, // R10 abort
        '{U, 32'h55550005, 3'd3, 1'b1, 1'b0, 2'b01, 4'd10}, // R10
        '{U, 32'h44440004, 3'd3, 1'b1, 1'b0, 2'b01, 4'd5},  // R5
        '{U, 32'h55550005, 3'd3, 1'b1, 1'b1, 2'b00, 4'd3},  // R3 unlocked
        '{S, 32'd1,        3'd1, 1'b1, 1'b1, 2'b00, 4'd4},  // R4 mode1 no pw
        '{U, 32'h00000000, 3'd1, 1'b1, 1'b1, 2'b00, 4'd5},  // R5 no pw
        '{S, 32'd4,        3'd4, 1'b1, 1'b1, 2'b00, 4'd2},  // R2
        '{S, 32'd6,        3'd4, 1'b1, 1'b1, 2'b00, 4'd11}  // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_UNLOCK;
        #1;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
        reg_addr = A_UNLOCK;
        #0.5;
    endtask

    task automatic state_is(input string tag, input logic [2:0] s, input logic rd,
                            input logic wr, input logic [1:0] st);
        chk({tag, " sel"}, 32'(blk_sel), 32'(s));
        chk({tag, " rd"}, 32'(rd_allow), 32'(rd));
        chk({tag, " wr"}, 32'(wr_allow), 32'(wr));
        chk({tag, " status"}, 32'(reg_rdata[1:0]), 32'(st));
    endtask

    task automatic preload(input int b, input logic [1:0] l, input logic p,
                           input logic [PWW-1:0] w);
        @(negedge clk);
        pl_valid = 1'b1; pl_blk = SW'(b); pl_len = l; pl_prot = p; pl_pw = w;
        @(negedge clk);
        pl_valid = 1'b0;
        reg_addr = A_UNLOCK;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; pl_valid = 1'b0; pl_blk = '0; pl_len = '0; pl_prot = 1'b0;
        pl_pw = '0; reg_we = 1'b0; reg_addr = A_UNLOCK; reg_wdata = '0;
        // preload while in reset (R13)
        preload(0, 2'd1, 1'b0, {32'h0, 32'h0, 32'hA0A00001});
        preload(1, 2'd0, 1'b1, '0);
        preload(2, 2'd3, 1'b1, {32'h33330003, 32'h22220002, 32'h11110001});
        preload(3, 2'd2, 1'b0, {32'h0, 32'h55550005, 32'h44440004});
        preload(4, 2'd0, 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        state_is("R1 after reset", 3'd0, 1'b1, 1'b0, 2'b11);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].a, VECS[i].d);
            state_is($sformatf("R%0d vec%0d", VECS[i].req, i),
                     VECS[i].sel, VECS[i].rd, VECS[i].wr, VECS[i].st);
        end

        // R12 read-back map
        peek(A_SEL, v);    chk("R12 select readback", v, 32'd4);
        peek(A_PW0, v);    chk("R12 password reads zero", v, 32'd0);
        peek(A_ACCESS, v); chk("R12 access readback", v, 32'h00);

        // R9 config writes on unlocked block 3
        op(A_SEL, 32'd3);
        state_is("R9 blk3 unlocked", 3'd3, 1'b1, 1'b1, 2'b00);
        op(A_ACCESS, 32'h12);
        peek(A_ACCESS, v); chk("R9 access accepted", v, 32'h12);
        op(3'd3, 32'h66660006);
        op(A_UNLOCK, 32'hFFFFFFFF);
        state_is("R9 blk3 relocked mode1", 3'd3, 1'b0, 1'b0, 2'b01);
        op(A_ACCESS, 32'h00);
        peek(A_ACCESS, v); chk("R9 access ignored locked", v, 32'h12);
        op(A_PW0, 32'hDEADBEEF);
        op(A_UNLOCK, 32'h44440004);
        op(A_UNLOCK, 32'h66660006);
        state_is("R9 new word1 old word0", 3'd3, 1'b1, 1'b1, 2'b00);

        // R9 password given through access field locks at once
        op(A_SEL, 32'd4);
        op(A_PW0, 32'h0BADF00D);
        op(A_ACCESS, 32'h01);
        state_is("R9 new password locks", 3'd4, 1'b1, 1'b0, 2'b01);
        op(A_UNLOCK, 32'h0BADF00D);
        state_is("R9 new password unlocks", 3'd4, 1'b1, 1'b1, 2'b00);

        // R8 master relocked: config and select ignored
        op(A_SEL, 32'd0);
        op(A_UNLOCK, 32'hFFFFFFFF);
        state_is("R8 master locked", 3'd0, 1'b1, 1'b0, 2'b11);
        op(A_ACCESS, 32'h00);
        peek(A_ACCESS, v); chk("R8 access ignored", v, 32'h01);
        op(A_SEL, 32'd3);
        chk("R8 select held", 32'(blk_sel), 32'd0);

        // R1 reset mid-run: locks set, configuration retained
        op(A_UNLOCK, 32'hA0A00001);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        state_is("R1 second reset", 3'd0, 1'b1, 1'b0, 2'b11);
        peek(A_ACCESS, v); chk("R1 config retained", v, 32'h01);
        op(A_UNLOCK, 32'hA0A00001);
        op(A_SEL, 32'd3);
        state_is("R1 blk3 relocked by reset", 3'd3, 1'b0, 1'b0, 2'b01);
        op(A_SEL, 32'd2);
        state_is("R1 blk2 relocked by reset", 3'd2, 1'b0, 1'b0, 2'b01);

        // R13 preload at run time
        preload(1, 2'd1, 1'b1, {64'h0, 32'h77770007});
        op(A_SEL, 32'd1);
        state_is("R13 preloaded blk1 locked", 3'd1, 1'b0, 1'b0, 2'b01);
        preload(0, 2'd1, 1'b0, {64'h0, 32'hA0A00001});
        state_is("R13 preload blk0 forces select", 3'd0, 1'b1, 1'b0, 2'b11);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule